// File: doc/BRIEF.md
# Accumulator Machine Execution Core (Data-Movement Subset)

This block is a multi-cycle execution core for a small 8-bit accumulator machine. It holds seven byte-wide scratchpad registers, A, B, C, D, E, H and L. It fetches instructions one byte per cycle from a 14-bit byte-addressed memory and runs the data-movement part of the instruction set: register-to-register moves, moves between a register and memory, immediate loads, increment and decrement, port input and output, and halt. Any opcode outside these groups passes through as a one-byte no-operation.

For memory operands the core uses H and L together as a pointer. The low six bits of H give the upper address bits and L gives the lower byte. Ports are reached over a separate bus: the core drives a port number, a read strobe and a write strobe. A halt stops all bus activity until the interrupt-request input is seen. Execution then continues at the byte after the halt. The zero, sign and parity flags are outputs, and so is a carry flag, which no instruction in this subset writes.

Top module: `acc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core fetches from address 0: mem_rd is 1, mem_addr is 0, halted is 0 and all four flags are 0.
- R2: An immediate load `00 ddd 110` followed by a data byte writes that byte to register ddd. The register codes are A=000, B=001, C=010, D=011, E=100, H=101, L=110. Flags do not change.
- R3: A move `11 ddd sss`, where neither field is 111, copies register sss into register ddd. Flags do not change.
- R4: A move with sss=111 loads register ddd from memory address {H[5:0], L}. Bits 7:6 of H are ignored.
- R5: A move with ddd=111 writes register sss to address {H[5:0], L}. An immediate load with ddd=111 (byte 0x3E) writes its data byte to that address. Each causes exactly one memory write.
- R6: `00 ddd 000` increments and `00 ddd 001` decrements register ddd (B to L), modulo 256. Zero is set when the result is 0, sign copies bit 7, and parity is set when the number of ones is even. Carry keeps its value.
- R7: `01 00m mm1` pulses io_rd for one cycle with io_port = mmm and loads A from io_rdata.
- R8: `01 rrm mm1` with rr not 00 pulses io_wr for one cycle with io_port = rrmmm and io_wdata = A.
- R9: 0x00, 0x01 and 0xFF halt the core. While halted, the core drives no memory or port strobe. 0xFF performs no memory access.
- R10: When irq is seen while halted, the core leaves the halted state and fetches the byte that follows the halt instruction.
- R11: Other opcodes are one-byte no-operations. Examples are 0x80, 0x44, and 0x38 (increment with ddd=111). They change no register, no flag and no memory.
- R12: The 14-bit program counter wraps from 0x3FFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 14 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe; read data is used in the same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| io_port | output | 5 | Port number |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | 8 | Port write data (A) |
| io_rdata | input | 8 | Port read data, taken in the io_rd cycle |
| irq | input | 1 | Interrupt request; releases the halted state |
| halted | output | 1 | Core is stopped |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Parity flag (even) |

## Verification
The bench targets the H register with its top bits set. A core that used all 16 bits of H:L would access the wrong location, so the loaded or stored byte would be missing. The 0xFF opcode sits in the move space; a decoder that treated it as a move would issue memory accesses instead of stopping. Increment from 0xFF and decrement from 0x00 test wraparound and the even-parity rule. The two port directions are told apart only by bits 5:4, so a decoder that mixed them up would write a port that should have been read. A full run past 0x3FFF shows whether the counter wraps back to the program at address 0, and waking from a halt shows whether execution resumes one byte past the halt rather than on it.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_IMM,
    ST_MRD,
    ST_MWR,
    ST_STOP
  } state_e;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_MOVRR,
    OP_LDMEM,
    OP_STMEM,
    OP_LDIMM,
    OP_STIMM,
    OP_INC,
    OP_DEC,
    OP_PIN,
    OP_POUT,
    OP_STOP
  } op_e;

  localparam logic [2:0] RSEL_A   = 3'd0;
  localparam logic [2:0] RSEL_H   = 3'd5;
  localparam logic [2:0] RSEL_L   = 3'd6;
  localparam logic [2:0] RSEL_MEM = 3'd7;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [7:0] ir,
  output op_e        op,
  output logic [2:0] dst,
  output logic [2:0] src
);
  always_comb begin
    dst = ir[5:3];
    src = ir[2:0];
    op  = OP_NOP;
    unique case (ir[7:6])
      2'b11: begin
        if (ir == 8'hFF)            op = OP_STOP;
        else if (ir[2:0] == RSEL_MEM) op = OP_LDMEM;
        else if (ir[5:3] == RSEL_MEM) op = OP_STMEM;
        else                          op = OP_MOVRR;
      end
      2'b00: begin
        if (ir[7:1] == 7'd0)          op = OP_STOP;
        else if (ir[2:0] == 3'b110)   op = (ir[5:3] == RSEL_MEM) ? OP_STIMM : OP_LDIMM;
        else if (ir[5:3] != RSEL_MEM && ir[2:0] == 3'b000) op = OP_INC;
        else if (ir[5:3] != RSEL_MEM && ir[2:0] == 3'b001) op = OP_DEC;
        else                          op = OP_NOP;
      end
      2'b01: begin
        if (ir[0]) op = (ir[5:4] == 2'b00) ? OP_PIN : OP_POUT;
      end
      default: op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int NREG = 7,
  parameter int W    = 8,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] rs_addr,
  output logic [W-1:0]  rs_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  a_val,
  output logic [W-1:0]  h_val,
  output logic [W-1:0]  l_val
);
  logic [NREG-1:0][W-1:0] bank;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [W-1:0] q;
    logic         en;
    assign en = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign bank[i] = q;
  end

  always_comb begin
    rs_data = '0;
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rs_addr == AW'(i)) rs_data = bank[i];
      if (rd_addr == AW'(i)) rd_data = bank[i];
    end
  end

  assign a_val = bank[acc_pkg::RSEL_A];
  assign h_val = bank[acc_pkg::RSEL_H];
  assign l_val = bank[acc_pkg::RSEL_L];
endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  output logic         z,
  output logic         s,
  output logic         p
);
  assign z = (res == '0);
  assign s = res[W-1];
  assign p = ~^res;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 14,
  parameter int PORT_W = 5,
  parameter int NREG   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PORT_W-1:0] io_port,
  output logic              io_rd,
  output logic              io_wr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic              irq,
  output logic              halted,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_p
);
  localparam int HBITS = ADDR_W - DATA_W;
  localparam int RAW   = 3;

  logic rst_i_n;
  acc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [7:0]        ir_q, ir_d;
  logic [DATA_W-1:0] tmp_q, tmp_d;
  logic              c_q, z_q, s_q, p_q;
  logic              c_d, z_d, s_d, p_d;

  op_e               op;
  logic [RAW-1:0]    dst, src;
  logic              rf_we;
  logic [RAW-1:0]    rf_waddr;
  logic [DATA_W-1:0] rf_wdata, rs_data, rd_data, a_val, h_val, l_val;
  logic [DATA_W-1:0] alu_res;
  logic              fz, fs, fp, flag_en;
  logic [ADDR_W-1:0] hl_addr;

  acc_decode u_dec (.ir(ir_q), .op(op), .dst(dst), .src(src));

  acc_regfile #(.NREG(NREG), .W(DATA_W), .AW(RAW)) u_rf (
    .clk(clk), .rst_n(rst_i_n),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .rs_addr(src), .rs_data(rs_data),
    .rd_addr(dst), .rd_data(rd_data),
    .a_val(a_val), .h_val(h_val), .l_val(l_val)
  );

  acc_flags #(.W(DATA_W)) u_flg (.res(alu_res), .z(fz), .s(fs), .p(fp));

  assign hl_addr = {h_val[HBITS-1:0], l_val};
  assign alu_res = (op == OP_DEC) ? rd_data - 1'b1 : rd_data + 1'b1;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ir_d      = ir_q;
    tmp_d     = tmp_q;
    rf_we     = 1'b0;
    rf_waddr  = dst;
    rf_wdata  = '0;
    mem_addr  = pc_q;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = tmp_q;
    io_rd     = 1'b0;
    io_wr     = 1'b0;
    io_port   = ir_q[PORT_W:1];
    io_wdata  = a_val;
    flag_en   = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd  = 1'b1;
        ir_d    = mem_rdata;
        pc_d    = pc_q + 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        state_d = ST_FETCH;
        unique case (op)
          OP_MOVRR: begin
            rf_we    = 1'b1;
            rf_wdata = rs_data;
          end
          OP_LDMEM: state_d = ST_MRD;
          OP_STMEM: begin
            tmp_d   = rs_data;
            state_d = ST_MWR;
          end
          OP_LDIMM, OP_STIMM: state_d = ST_IMM;
          OP_INC, OP_DEC: begin
            rf_we    = 1'b1;
            rf_wdata = alu_res;
            flag_en  = 1'b1;
          end
          OP_PIN: begin
            io_rd    = 1'b1;
            rf_we    = 1'b1;
            rf_waddr = RSEL_A;
            rf_wdata = io_rdata;
          end
          OP_POUT: io_wr = 1'b1;
          OP_STOP: state_d = ST_STOP;
          default: state_d = ST_FETCH;
        endcase
      end
      ST_IMM: begin
        mem_rd = 1'b1;
        pc_d   = pc_q + 1'b1;
        if (op == OP_STIMM) begin
          tmp_d   = mem_rdata;
          state_d = ST_MWR;
        end else begin
          rf_we    = 1'b1;
          rf_wdata = mem_rdata;
          state_d  = ST_FETCH;
        end
      end
      ST_MRD: begin
        mem_addr = hl_addr;
        mem_rd   = 1'b1;
        rf_we    = 1'b1;
        rf_wdata = mem_rdata;
        state_d  = ST_FETCH;
      end
      ST_MWR: begin
        mem_addr = hl_addr;
        mem_wr   = 1'b1;
        state_d  = ST_FETCH;
      end
      ST_STOP: begin
        if (irq) state_d = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_comb begin
    c_d = c_q;
    z_d = flag_en ? fz : z_q;
    s_d = flag_en ? fs : s_q;
    p_d = flag_en ? fp : p_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      tmp_q   <= '0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
      s_q     <= 1'b0;
      p_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      tmp_q   <= tmp_d;
      c_q     <= c_d;
      z_q     <= z_d;
      s_q     <= s_d;
      p_q     <= p_d;
    end
  end

  assign halted = (state_q == ST_STOP);
  assign flag_c = c_q;
  assign flag_z = z_q;
  assign flag_s = s_q;
  assign flag_p = p_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int PORT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [PORT_W-1:0] io_port,
  input logic              irq,
  input logic              halted
);
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(mem_rd || mem_wr || io_rd || io_wr));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

  // R7
  in_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |-> (io_port[PORT_W-1:PORT_W-2] == 2'b00));

  // R8
  out_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> (io_port[PORT_W-1:PORT_W-2] != 2'b00));

  // R10
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> (mem_rd && $past(irq)));
endmodule

bind acc_core acc_core_chk #(.PORT_W(PORT_W)) u_acc_core_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .io_port(io_port), .irq(irq), .halted(halted)
);

// File: tb/test_acc_core.sv
module test_acc_core;
  logic        clk;
  logic        rst_n;
  logic [13:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [4:0]  io_port;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata, io_rdata;
  logic        irq, halted;
  logic        flag_c, flag_z, flag_s, flag_p;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [256];
  logic [7:0] in_base;
  int         ld_ptr;

  logic [4:0]  out_port_log [16];
  logic [7:0]  out_data_log [16];
  logic [13:0] wr_addr_log  [16];
  logic [7:0]  wr_data_log  [16];
  logic [4:0]  in_port_log  [16];
  int n_out, n_wr, n_in;

  acc_core i_acc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_port(io_port), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .irq(irq), .halted(halted), .flag_c(flag_c),
    .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_comb mem_rdata = (mem_addr < 14'd256) ? mem[mem_addr[7:0]] : 8'hC0;
  always_comb io_rdata  = in_base + {3'b000, io_port};

  always @(posedge clk) begin
    if (!rst_n) begin
      n_out <= 0; n_wr <= 0; n_in <= 0;
    end else begin
      if (io_wr && n_out < 16) begin
        out_port_log[n_out] <= io_port;
        out_data_log[n_out] <= io_wdata;
        n_out <= n_out + 1;
      end
      if (io_rd && n_in < 16) begin
        in_port_log[n_in] <= io_port;
        n_in <= n_in + 1;
      end
      if (mem_wr) begin
        if (mem_addr < 14'd256) mem[mem_addr[7:0]] <= mem_wdata;
        if (n_wr < 16) begin
          wr_addr_log[n_wr] <= mem_addr;
          wr_data_log[n_wr] <= mem_wdata;
          n_wr <= n_wr + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    mem[ld_ptr[7:0]] = b;
    ld_ptr++;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    irq = 1'b0;
    in_base = 8'h00;
    for (int i = 0; i < 256; i++) mem[i] = 8'hC0;
    ld_ptr = 0;
  endtask

  task automatic release_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(input string req, input int limit);
    int n;
    n = 0;
    @(negedge clk);
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk({req, " halt reached"}, 32'(halted), 32'd1);
  endtask

  task automatic pulse_irq();
    @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
  endtask

  task automatic t_reset();
    hold_reset();
    put(8'h00);
    @(negedge clk);
    chk("R1 mem_rd", 32'(mem_rd), 1);
    chk("R1 mem_addr", 32'(mem_addr), 0);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 flags", 32'({flag_c, flag_z, flag_s, flag_p}), 0);
    release_reset();
    @(negedge clk);
    chk("R1 first fetch addr", 32'(mem_addr), 0);
    wait_halt("R1", 50);
  endtask

  task automatic t_moves();
    hold_reset();
    put(8'h0E); put(8'h3C); put(8'hC1); put(8'h51);
    put(8'h16); put(8'h81); put(8'hC2); put(8'h53); put(8'h00);
    release_reset();
    wait_halt("R2", 200);
    chk("R2 out count", 32'(n_out), 2);
    chk("R2 R3 out0 port", 32'(out_port_log[0]), 8);
    chk("R2 R3 out0 data", 32'(out_data_log[0]), 32'h3C);
    chk("R3 out1 port", 32'(out_port_log[1]), 9);
    chk("R2 R3 out1 data", 32'(out_data_log[1]), 32'h81);
    chk("R2 flags unchanged", 32'({flag_c, flag_z, flag_s, flag_p}), 0);
    chk("R3 no mem write", 32'(n_wr), 0);
  endtask

  task automatic t_memory();
    hold_reset();
    mem[8'h80] = 8'h5A;
    put(8'h2E); put(8'hC0); put(8'h36); put(8'h80);
    put(8'hDF); put(8'hC3); put(8'h51);
    put(8'h36); put(8'h90); put(8'h06); put(8'h77); put(8'hF8);
    put(8'h36); put(8'h91); put(8'h3E); put(8'h33); put(8'h00);
    release_reset();
    wait_halt("R4", 300);
    chk("R4 load via H:L", 32'(out_data_log[0]), 32'h5A);
    chk("R5 write count", 32'(n_wr), 2);
    chk("R5 store addr", 32'(wr_addr_log[0]), 32'h0090);
    chk("R5 store data", 32'(wr_data_log[0]), 32'h77);
    chk("R5 imm store addr", 32'(wr_addr_log[1]), 32'h0091);
    chk("R5 imm store data", 32'(wr_data_log[1]), 32'h33);
    chk("R5 flags unchanged", 32'({flag_c, flag_z, flag_s, flag_p}), 0);
  endtask

  task automatic t_incdec();
    hold_reset();
    put(8'h0E); put(8'hFF); put(8'h08); put(8'hC1); put(8'h51); put(8'h00);
    release_reset();
    wait_halt("R6", 200);
    chk("R6 inc wrap value", 32'(out_data_log[0]), 0);
    chk("R6 inc flags csz p", 32'({flag_c, flag_z, flag_s, flag_p}), 32'b0101);

    hold_reset();
    put(8'h26); put(8'h00); put(8'h21); put(8'h00);
    release_reset();
    wait_halt("R6", 200);
    chk("R6 dec flags csz p", 32'({flag_c, flag_z, flag_s, flag_p}), 32'b0011);

    hold_reset();
    put(8'h16); put(8'h06); put(8'h10); put(8'hC2); put(8'h51); put(8'h00);
    release_reset();
    wait_halt("R6", 200);
    chk("R6 inc value", 32'(out_data_log[0]), 7);
    chk("R6 odd parity flags", 32'({flag_c, flag_z, flag_s, flag_p}), 32'b0000);
  endtask

  task automatic t_ports();
    hold_reset();
    in_base = 8'h20;
    put(8'h4B); put(8'h7F); put(8'h41); put(8'h61); put(8'h00);
    release_reset();
    wait_halt("R7", 200);
    chk("R7 in count", 32'(n_in), 2);
    chk("R7 in port 5", 32'(in_port_log[0]), 5);
    chk("R7 in port 0", 32'(in_port_log[1]), 0);
    chk("R8 out port 31", 32'(out_port_log[0]), 31);
    chk("R7 R8 data 0x25", 32'(out_data_log[0]), 32'h25);
    chk("R8 out port 16", 32'(out_port_log[1]), 16);
    chk("R7 R8 data 0x20", 32'(out_data_log[1]), 32'h20);
  endtask

  task automatic t_halt_wake();
    hold_reset();
    put(8'h06); put(8'h12); put(8'hFF); put(8'h51); put(8'h01);
    release_reset();
    wait_halt("R9", 200);
    repeat (20) @(negedge clk);
    chk("R9 stays halted", 32'(halted), 1);
    chk("R9 no fetch", 32'(mem_rd), 0);
    chk("R9 no output yet", 32'(n_out), 0);
    chk("R9 0xFF no mem write", 32'(n_wr), 0);
    pulse_irq();
    wait_halt("R10", 200);
    chk("R10 resumed out count", 32'(n_out), 1);
    chk("R10 resumed out data", 32'(out_data_log[0]), 32'h12);
  endtask

  task automatic t_nops();
    hold_reset();
    put(8'h0E); put(8'h55); put(8'h06); put(8'h21);
    put(8'h80); put(8'h44); put(8'h38);
    put(8'h51); put(8'hC1); put(8'h53); put(8'h00);
    release_reset();
    wait_halt("R11", 200);
    chk("R11 A kept", 32'(out_data_log[0]), 32'h21);
    chk("R11 B kept", 32'(out_data_log[1]), 32'h55);
    chk("R11 no mem write", 32'(n_wr), 0);
    chk("R11 flags kept", 32'({flag_c, flag_z, flag_s, flag_p}), 0);
  endtask

  task automatic t_wrap();
    hold_reset();
    in_base = 8'h10;
    put(8'h45); put(8'h51); put(8'h00);
    release_reset();
    wait_halt("R12", 100);
    chk("R12 first pass", 32'(out_data_log[0]), 32'h12);
    in_base = 8'h40;
    pulse_irq();
    wait_halt("R12", 40000);
    chk("R12 second pass count", 32'(n_out), 2);
    chk("R12 wrapped to 0", 32'(out_data_log[1]), 32'h42);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq = 1'b0;
    in_base = 8'h00;
    t_reset();
    t_moves();
    t_memory();
    t_incdec();
    t_ports();
    t_halt_wake();
    t_nops();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule